// File: doc/BRIEF.md
# Prescaled Asynchronous Edge Synchronizer

This block turns one free-running signal that has no phase relation to the system clock into count-enable pulses in the system clock domain. The raw input first clocks a small divider of up to two bits. The divider is clocked by the input itself, so it can follow input rates above the system clock. The chosen divider tap, or the raw input when bypass is selected, then goes through a two-flop synchronizer. A rising-edge detector follows. Every rising edge of the synchronized level gives exactly one system-clock-wide enable pulse.

A downstream counter adds up the pulses and multiplies its result by the reported divide ratio. A sticky flag warns that rising edges arrived close enough together that edges may have been merged or lost while crossing domains. The enable output stays blanked for the first three system clocks after reset is released. This stops a level that was already high during reset from being seen as an edge.

Top module: `prescaled_tick_sync`

## Requirements
- R1: While reset is asserted (rst_ni low), tick_o and overrun_o are low, and the divider and synchronizer hold zero.
- R2: With div_sel_i = 0 (bypass), every rising edge of ext_i gives exactly one tick_o pulse, and that pulse is one system clock wide.
- R3: With div_sel_i = 1, the divider output is its bit 0, so tick_o pulses once for every two rising edges of ext_i. The first pulse follows the first input edge after reset.
- R4: With div_sel_i = 2 or 3, the divider output is its bit 1, so tick_o pulses once for every four rising edges of ext_i. Input rates above the system clock are accepted in this mode.
- R5: div_ratio_o reads 1 for div_sel_i = 0, 2 for div_sel_i = 1, and 4 for div_sel_i = 2 or 3.
- R6: In bypass mode, an input rise that is set up before a system clock edge gives a tick_o that is high in the cycle after the second such edge and low in the cycle after the third.
- R7: tick_o stays low for the first three system clock edges after reset release, even when the synchronized level rises during that window.
- R8: overrun_o is set when a synchronized rising edge arrives exactly two system clocks after the previous one. Edges that are three or more clocks apart never set it.
- R9: Once set, overrun_o stays high until clr_ovr_i is sampled high at a clock edge. It is then low in the next cycle, unless a new overrun happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously |
| ext_i | input | 1 | Raw external signal, asynchronous to clk_i |
| div_sel_i | input | 2 | Divide select: 0 bypass, 1 divide by 2, 2 or 3 divide by 4 |
| clr_ovr_i | input | 1 | Clears the sticky overrun flag |
| tick_o | output | 1 | One-cycle count enable for each synchronized rising edge |
| div_ratio_o | output | 3 | Divide ratio now in use |
| overrun_o | output | 1 | Sticky flag for rising edges that were too close together |

## Verification
The hardest case to reach is an input level that is already high when reset is released. The edge detector then sees a real rise inside the blanking window, and only the blanking stops it from becoming a pulse. The stimulus holds ext_i high through reset in bypass mode and confirms that no pulse appears, then confirms that the next real edge is counted. Overrun spacing is controlled by placing input edges at a fixed offset just before system clock edges, with periods of exactly two and three clocks, so the synchronized edge spacing is known exactly.

// File: rtl/tick_sync_pkg.sv
`timescale 1ns/1ps
package tick_sync_pkg;

   // divide select encoding seen on div_sel_i
   typedef enum logic [1:0] {
      DIV_BY1  = 2'd0,
      DIV_BY2  = 2'd1,
      DIV_BY4  = 2'd2,
      DIV_BY4B = 2'd3
   } div_mode_e;

   localparam int unsigned MAX_PS_BITS = 2;
   localparam int unsigned RATIO_W     = MAX_PS_BITS + 1;

endpackage

// File: rtl/ext_prescaler.sv
`timescale 1ns/1ps
module ext_prescaler
   import tick_sync_pkg::*;
#(
   parameter int unsigned PS_BITS = 2
)(
   input  logic       ext_i,
   input  logic       rst_ni,
   input  logic [1:0] sel_i,
   output logic       lvl_o
);

   logic [PS_BITS-1:0] cnt_q;

   // divider runs in the input's own domain
   always_ff @(posedge ext_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (PS_BITS == 1) begin : g_one_bit
         always_comb begin
            if (div_mode_e'(sel_i) == DIV_BY1) lvl_o = ext_i;
            else                               lvl_o = cnt_q[0];
         end
      end else begin : g_two_bit
         always_comb begin
            unique case (div_mode_e'(sel_i))
               DIV_BY1: lvl_o = ext_i;
               DIV_BY2: lvl_o = cnt_q[0];
               default: lvl_o = cnt_q[PS_BITS-1];
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/sync_chain.sv
`timescale 1ns/1ps
module sync_chain #(
   parameter int unsigned STAGES = 2
)(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] stg_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stg_q[0] <= 1'b0;
               else         stg_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stg_q[gi] <= 1'b0;
               else         stg_q[gi] <= stg_q[gi-1];
            end
         end
      end
   endgenerate

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rise_qualifier.sv
`timescale 1ns/1ps
module rise_qualifier #(
   parameter int unsigned BLANK_CYCLES = 3,
   parameter int unsigned MIN_SPACING  = 3
)(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   input  logic clr_i,
   output logic rise_o,
   output logic tick_o,
   output logic overrun_o
);

   localparam int unsigned BW = $clog2(BLANK_CYCLES + 1);
   localparam int unsigned GW = $clog2(MIN_SPACING + 1);
   localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYCLES);
   localparam logic [GW-1:0] GAP_SAT   = GW'(MIN_SPACING);

   logic          prev_q;
   logic [BW-1:0] blank_q;
   logic [GW-1:0] gap_q;
   logic          ovr_q;
   logic          armed;
   logic          too_close;

   assign rise_o    = lvl_i & ~prev_q;
   assign armed     = (blank_q == BLANK_END);
   assign too_close = rise_o & (gap_q < GAP_SAT);
   assign tick_o    = rise_o & armed;
   assign overrun_o = ovr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     blank_q <= '0;
      else if (!armed) blank_q <= blank_q + 1'b1;
   end

   // clocks since the last rise, saturating so the first rise never counts
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               gap_q <= GAP_SAT;
      else if (rise_o)           gap_q <= GW'(1);
      else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ovr_q <= 1'b0;
      else if (too_close) ovr_q <= 1'b1;
      else if (clr_i)     ovr_q <= 1'b0;
   end

endmodule

// File: rtl/prescaled_tick_sync.sv
`timescale 1ns/1ps
module prescaled_tick_sync
   import tick_sync_pkg::*;
#(
   parameter int unsigned PS_BITS      = 2,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned BLANK_CYCLES = 3,
   parameter int unsigned MIN_SPACING  = 3
)(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ext_i,
   input  logic [1:0] div_sel_i,
   input  logic       clr_ovr_i,
   output logic       tick_o,
   output logic [2:0] div_ratio_o,
   output logic       overrun_o
);

   localparam logic [2:0] RATIO_MID = (PS_BITS >= 1) ? 3'd2 : 3'd1;
   localparam logic [2:0] RATIO_TOP = 3'(1 << PS_BITS);

   generate
      if (PS_BITS < 1 || PS_BITS > MAX_PS_BITS) begin : g_bad_ps
         $error("PS_BITS must be 1 or 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_SPACING < 3) begin : g_bad_gap
         $error("MIN_SPACING must be at least 3");
      end
   endgenerate

   logic sel_lvl;
   logic sync_lvl;
   logic rise_w;

   ext_prescaler #(.PS_BITS(PS_BITS)) u_ps (
      .ext_i  (ext_i),
      .rst_ni (rst_ni),
      .sel_i  (div_sel_i),
      .lvl_o  (sel_lvl)
   );

   sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (sel_lvl),
      .q_o    (sync_lvl)
   );

   rise_qualifier #(
      .BLANK_CYCLES (BLANK_CYCLES),
      .MIN_SPACING  (MIN_SPACING)
   ) u_rq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (sync_lvl),
      .clr_i     (clr_ovr_i),
      .rise_o    (rise_w),
      .tick_o    (tick_o),
      .overrun_o (overrun_o)
   );

   always_comb begin
      unique case (div_mode_e'(div_sel_i))
         DIV_BY1: div_ratio_o = 3'd1;
         DIV_BY2: div_ratio_o = RATIO_MID;
         default: div_ratio_o = RATIO_TOP;
      endcase
   end

endmodule

// File: rtl/prescaled_tick_sync_chk.sv
`timescale 1ns/1ps
module prescaled_tick_sync_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] div_sel_i,
   input logic       clr_ovr_i,
   input logic       tick_o,
   input logic [2:0] div_ratio_o,
   input logic       overrun_o,
   input logic       rise_w
);

   logic [1:0] since_rst;
   logic       primed;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   always_ff @(posedge clk_i) primed <= 1'b1;

   // R1
   always @(negedge clk_i) begin
      if (primed === 1'b1 && !rst_ni)
         reset_quiet_chk: assert (!tick_o && !overrun_o);
   end

   // R5
   always @(negedge clk_i) begin
      if (primed === 1'b1)
         ratio_map_chk: assert ((div_sel_i == 2'd0 && div_ratio_o == 3'd1) ||
                                (div_sel_i == 2'd1 && div_ratio_o == 3'd2) ||
                                (div_sel_i[1]      && div_ratio_o == 3'd4));
   end

   // R2
   tick_one_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

   // R7
   blank_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst != 2'd3) |-> !tick_o);

   // R8
   ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(overrun_o) |-> $past(rise_w));

   // R9
   ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (overrun_o && !clr_ovr_i) |=> overrun_o);

endmodule

bind prescaled_tick_sync prescaled_tick_sync_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .div_sel_i   (div_sel_i),
   .clr_ovr_i   (clr_ovr_i),
   .tick_o      (tick_o),
   .div_ratio_o (div_ratio_o),
   .overrun_o   (overrun_o),
   .rise_w      (rise_w)
);

// File: tb/prescaled_tick_sync_tb.sv
`timescale 1ns/1ps
module prescaled_tick_sync_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       ext = 1'b0;
   logic [1:0] sel = 2'd0;
   logic       clr = 1'b0;
   logic       tick;
   logic [2:0] ratio;
   logic       ovr;

   int n_chk = 0;
   int n_err = 0;
   int tick_cnt = 0;
   int wide_cnt = 0;
   logic tick_prev = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   prescaled_tick_sync u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ext_i       (ext),
      .div_sel_i   (sel),
      .clr_ovr_i   (clr),
      .tick_o      (tick),
      .div_ratio_o (ratio),
      .overrun_o   (ovr)
   );

   always @(negedge clk) begin
      if (tick) tick_cnt++;
      if (tick && tick_prev) wide_cnt++;
      tick_prev = tick;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] s, input logic ext_lvl);
      @(negedge clk);
      rst_n = 1'b0;
      ext = 1'b0;
      sel = s;
      clr = 1'b0;
      #1 ext = ext_lvl;
      repeat (3) @(negedge clk);
      chk("R1 tick in reset", int'(tick), 0);
      chk("R1 overrun in reset", int'(ovr), 0);
      rst_n = 1'b1;
   endtask

   // edges land 1 ns ahead of a rising clock edge
   task automatic pulses(input int n, input int half);
      @(negedge clk);
      #3;
      repeat (n) begin
         ext = 1'b1; #(half);
         ext = 1'b0; #(half);
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic t_ratio;
      for (int s = 0; s < 4; s++) begin
         sel = 2'(s);
         #1;
         chk("R5 div_ratio", int'(ratio), (s == 0) ? 1 : (s == 1) ? 2 : 4);
      end
   endtask

   task automatic t_bypass;
      do_reset(2'd0, 1'b0);
      repeat (5) @(negedge clk);
      tick_cnt = 0; wide_cnt = 0;
      pulses(10, 12);
      chk("R2 ticks per edge", tick_cnt, 10);
      chk("R2 tick width", wide_cnt, 0);
      chk("R8 no overrun at 3-clock spacing", int'(ovr), 0);
   endtask

   task automatic t_latency;
      do_reset(2'd0, 1'b0);
      repeat (5) @(negedge clk);
      #3 ext = 1'b1;
      @(negedge clk); chk("R6 tick after 1st edge", int'(tick), 0);
      @(negedge clk); chk("R6 tick after 2nd edge", int'(tick), 1);
      @(negedge clk); chk("R6 tick after 3rd edge", int'(tick), 0);
      ext = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_div2;
      do_reset(2'd1, 1'b0);
      repeat (5) @(negedge clk);
      tick_cnt = 0;
      pulses(20, 6);
      chk("R3 ticks for 20 edges", tick_cnt, 10);
   endtask

   task automatic t_div4(input logic [1:0] s);
      do_reset(s, 1'b0);
      repeat (5) @(negedge clk);
      tick_cnt = 0;
      pulses(40, 3);   // input faster than the system clock
      chk("R4 ticks for 40 fast edges", tick_cnt, 10);
      chk("R4 no overrun", int'(ovr), 0);
   endtask

   task automatic t_blank;
      do_reset(2'd0, 1'b1);   // input already high at release
      tick_cnt = 0;
      repeat (10) @(negedge clk);
      chk("R7 no tick from level held through reset", tick_cnt, 0);
      ext = 1'b0;
      repeat (4) @(negedge clk);
      pulses(1, 12);
      chk("R7 first real edge counted", tick_cnt, 1);
   endtask

   task automatic t_overrun;
      do_reset(2'd0, 1'b0);
      repeat (5) @(negedge clk);
      pulses(10, 8);
      chk("R8 overrun at 2-clock spacing", int'(ovr), 1);
      repeat (10) @(negedge clk);
      chk("R9 overrun sticky", int'(ovr), 1);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      chk("R9 overrun cleared", int'(ovr), 0);
      pulses(5, 12);
      chk("R9 stays clear at safe spacing", int'(ovr), 0);
   endtask

   initial begin
      #2 rst_n = 1'b0;
      fork
         begin
            t_ratio();
            t_bypass();
            t_latency();
            t_div2();
            t_div4(2'd2);
            t_div4(2'd3);
            t_blank();
            t_overrun();
         end
         begin
            #500000;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule